// File: doc/BRIEF.md
# Tagged Debug Channel FIFO Controller

This block is a register-mapped bridge between software and an external debug probe. Software sends words to the probe through a transmit FIFO and receives words from it through a receive FIFO. Every word in either FIFO carries a 4-bit channel tag. That lets sixteen logical streams share one physical pair of queues.

On the transmit side, software chooses the channel by the address it writes: each of the sixteen transmit data registers pushes its word tagged with that register's index. On the receive side, the status register shows the tag of the word at the head of the queue, so software can route that word before it pops it through the receive data register.

A configuration register reports both FIFO depths. It also holds two threshold selectors, one for transmit and one for receive, which together drive a single level-sensitive interrupt. The probe side is a plain push/pop port pair.

Top module: `dbgchan_fifo`

## Requirements
- R1: After reset, both FIFOs are empty. Status reads 0x0000000A, the interrupt output is 0, and configuration reads the transmit depth in bits 15:8 and the receive depth in bits 7:0, with bits 19:16 equal to 0.
- R2: A bus write to offset 0x20 + 8*n (n = 0..15) appends the write data to the transmit FIFO with tag n. The probe side presents words in arrival order, with data on `probe_tx_data` and tag on `probe_tx_chan`, and `probe_tx_pop` removes the head word.
- R3: A bus read of offset 0x18 returns the head word of the receive FIFO and removes it. Status bits 7:4 always show the tag of the current head, and show 0 when the FIFO is empty.
- R4: Status at offset 0x10 packs the following fields: transmit occupancy in bits 31:24, receive occupancy in bits 23:16, receive-empty in bit 3, receive-full in bit 2, transmit-empty in bit 1 and transmit-full in bit 0. All other bits read 0.
- R5: Configuration at offset 0x08 takes writes only in bits 19:18 (transmit selector) and 17:16 (receive selector). Its depth fields ignore writes.
- R6: A transmit write while the transmit FIFO is full is discarded and sets a sticky overflow flag in bit 0 of offset 0x00. Writing 1 to that bit clears the flag.
- R7: A read of offset 0x18 while the receive FIFO is empty returns 0 and changes no occupancy.
- R8: The transmit selector picks one of four conditions. 0 is off. 1 is occupancy equal to 0. 2 is occupancy below depth. 3 is 4*occupancy <= depth.
- R9: The receive selector picks one of four conditions. 0 is off. 1 is occupancy equal to depth. 2 is occupancy nonzero. 3 is 4*occupancy >= 3*depth.
- R10: `irq` is the OR of both selected conditions, taken from the state one clock earlier. It is registered and level sensitive.
- R11: `probe_rx_ready` is low exactly when the receive FIFO is full. A probe push at that time is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational for the current access |
| probe_tx_valid | output | 1 | Transmit FIFO holds a word |
| probe_tx_data | output | 32 | Transmit head data |
| probe_tx_chan | output | 4 | Transmit head tag |
| probe_tx_pop | input | 1 | Probe removes the transmit head |
| probe_rx_ready | output | 1 | Receive FIFO has room |
| probe_rx_push | input | 1 | Probe appends a word |
| probe_rx_data | input | 32 | Word to append |
| probe_rx_chan | input | 4 | Tag of word to append |
| irq | output | 1 | Interrupt request |

## Verification
A directed prologue checks the reset values. It then fills the transmit FIFO past its depth to trigger and clear the overflow flag, and reads the empty receive register. After that, random traffic alternates between phases that favour filling and phases that favour draining, so every threshold mode is observed both asserted and deasserted and both FIFOs reach full and empty. Channels and payloads are random, which separates tag errors from ordering errors. Same-cycle bus pushes with probe pops, and bus pops with probe pushes, test whether the occupancy bookkeeping is right when both ends move at once. The interrupt level is compared every cycle against the conditions of the previous cycle, which exposes a missing or extra register stage.

// File: rtl/dbgchan_fifo.sv
module dbgchan_fifo #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        probe_tx_valid,
  output logic [31:0] probe_tx_data,
  output logic [3:0]  probe_tx_chan,
  input  logic        probe_tx_pop,
  output logic        probe_rx_ready,
  input  logic        probe_rx_push,
  input  logic [31:0] probe_rx_data,
  input  logic [3:0]  probe_rx_chan,
  output logic        irq
);
  localparam int TAW = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int RAW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam logic [TAW:0] TX_FULLC = TX_DEPTH[TAW:0];
  localparam logic [RAW:0] RX_FULLC = RX_DEPTH[RAW:0];

  logic [35:0] tx_mem [TX_DEPTH];
  logic [35:0] rx_mem [RX_DEPTH];
  logic [TAW-1:0] tx_wp, tx_rp;
  logic [RAW-1:0] rx_wp, rx_rp;
  logic [TAW:0] tx_cnt;
  logic [RAW:0] rx_cnt;
  logic [1:0] tx_sel, rx_sel;
  logic ovf;

  logic tx_full, tx_empty, rx_full, rx_empty;
  assign tx_full  = tx_cnt == TX_FULLC;
  assign tx_empty = tx_cnt == '0;
  assign rx_full  = rx_cnt == RX_FULLC;
  assign rx_empty = rx_cnt == '0;

  logic [7:0] tx_off;
  logic tx_hit, tx_wr, tx_push, tx_pop, rx_rd, rx_pop, rx_push;
  assign tx_off  = bus_addr - 8'h20;
  assign tx_hit  = (bus_addr >= 8'h20) && (bus_addr <= 8'h98) && (bus_addr[2:0] == 3'b000);
  assign tx_wr   = bus_sel && bus_wr && tx_hit;
  assign tx_push = tx_wr && !tx_full;
  assign tx_pop  = probe_tx_pop && !tx_empty;
  assign rx_rd   = bus_sel && !bus_wr && (bus_addr == 8'h18);
  assign rx_pop  = rx_rd && !rx_empty;
  assign rx_push = probe_rx_push && !rx_full;

  assign probe_tx_valid = !tx_empty;
  assign probe_tx_data  = tx_mem[tx_rp][31:0];
  assign probe_tx_chan  = tx_mem[tx_rp][35:32];
  assign probe_rx_ready = !rx_full;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= {tx_off[6:3], bus_wdata};
    if (rx_push) rx_mem[rx_wp] <= {probe_rx_chan, probe_rx_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == TAW'(TX_DEPTH - 1)) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == TAW'(TX_DEPTH - 1)) ? '0 : tx_rp + 1'b1;
      if (rx_push) rx_wp <= (rx_wp == RAW'(RX_DEPTH - 1)) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == RAW'(RX_DEPTH - 1)) ? '0 : rx_rp + 1'b1;
      if (tx_push && !tx_pop) tx_cnt <= tx_cnt + 1'b1;
      else if (tx_pop && !tx_push) tx_cnt <= tx_cnt - 1'b1;
      if (rx_push && !rx_pop) rx_cnt <= rx_cnt + 1'b1;
      else if (rx_pop && !rx_push) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sel <= 2'd0; rx_sel <= 2'd0; ovf <= 1'b0;
    end else begin
      if (bus_sel && bus_wr && bus_addr == 8'h08) begin
        tx_sel <= bus_wdata[19:18];
        rx_sel <= bus_wdata[17:16];
      end
      if (tx_wr && tx_full) ovf <= 1'b1;
      else if (bus_sel && bus_wr && bus_addr == 8'h00 && bus_wdata[0]) ovf <= 1'b0;
    end
  end

  logic tx_cond, rx_cond;
  always_comb begin
    unique case (tx_sel)
      2'd1:    tx_cond = tx_empty;
      2'd2:    tx_cond = !tx_full;
      2'd3:    tx_cond = (32'(tx_cnt) * 4) <= TX_DEPTH;
      default: tx_cond = 1'b0;
    endcase
    unique case (rx_sel)
      2'd1:    rx_cond = rx_full;
      2'd2:    rx_cond = !rx_empty;
      2'd3:    rx_cond = (32'(rx_cnt) * 4) >= (3 * RX_DEPTH);
      default: rx_cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tx_cond || rx_cond;
  end

  logic [3:0] rx_head_chan;
  assign rx_head_chan = rx_empty ? 4'd0 : rx_mem[rx_rp][35:32];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        8'h00: bus_rdata = {31'd0, ovf};
        8'h08: bus_rdata = {12'd0, tx_sel, rx_sel, 8'(TX_DEPTH), 8'(RX_DEPTH)};
        8'h10: bus_rdata = {8'(tx_cnt), 8'(rx_cnt), 8'd0, rx_head_chan,
                            rx_empty, rx_full, tx_empty, tx_full};
        8'h18: bus_rdata = rx_empty ? 32'd0 : rx_mem[rx_rp][31:0];
        default: bus_rdata = '0;
      endcase
    end
  end

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full) |=> ovf);
  // R6
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full && !probe_tx_pop) |=> $stable(tx_cnt));
  // R7
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty && !probe_rx_push) |=> (rx_cnt == '0));
  // R3
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_empty && !probe_rx_push) |=> (rx_cnt == $past(rx_cnt) - 1'b1));
  // R8
  tx_empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel == 2'd1 && tx_cnt == '0) |=> irq);
  // R9
  rx_full_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sel == 2'd1 && rx_full) |=> irq);
  // R11
  rx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_rx_push && !probe_rx_ready && !rx_rd) |=> $stable(rx_cnt));
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= TX_FULLC) && (rx_cnt <= RX_FULLC));
endmodule

// File: tb/tb_dbgchan_fifo.sv
module tb_dbgchan_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 8;
  localparam int RXD = 8;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic probe_tx_valid, probe_tx_pop = 0;
  logic [31:0] probe_tx_data;
  logic [3:0] probe_tx_chan;
  logic probe_rx_ready, probe_rx_push = 0;
  logic [31:0] probe_rx_data = 0;
  logic [3:0] probe_rx_chan = 0;
  logic irq;

  dbgchan_fifo #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [35:0] mtx[$];
  logic [35:0] mrx[$];
  logic [1:0] m_txsel = 0, m_rxsel = 0;
  logic m_ovf = 0, prev_cond = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic model_cond();
    logic t, r;
    int tc, rc;
    tc = mtx.size(); rc = mrx.size();
    case (m_txsel)
      2'd1: t = (tc == 0);
      2'd2: t = (tc < TXD);
      2'd3: t = (tc * 4 <= TXD);
      default: t = 0;
    endcase
    case (m_rxsel)
      2'd1: r = (rc == RXD);
      2'd2: r = (rc != 0);
      2'd3: r = (rc * 4 >= 3 * RXD);
      default: r = 0;
    endcase
    return t | r;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [3:0] hc;
    hc = (mrx.size() != 0) ? mrx[0][35:32] : 4'd0;
    case (a)
      8'h00: return {31'd0, m_ovf};
      8'h08: return {12'd0, m_txsel, m_rxsel, 8'(TXD), 8'(RXD)};
      8'h10: return {8'(mtx.size()), 8'(mrx.size()), 8'd0, hc,
                     mrx.size() == 0, mrx.size() == RXD,
                     mtx.size() == 0, mtx.size() == TXD};
      8'h18: return (mrx.size() != 0) ? mrx[0][31:0] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input logic sel, input logic wr, input logic [7:0] a,
                      input logic [31:0] wd, input logic rxp, input logic [3:0] rxc,
                      input logic [31:0] rxd, input logic txp, input string req);
    logic txfull_pre, txempty_pre, rxfull_pre, rxempty_pre, cnd;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    probe_rx_push = rxp; probe_rx_chan = rxc; probe_rx_data = rxd;
    probe_tx_pop = txp;
    #1;
    txfull_pre = mtx.size() == TXD; txempty_pre = mtx.size() == 0;
    rxfull_pre = mrx.size() == RXD; rxempty_pre = mrx.size() == 0;
    chk("R10 irq level", 32'(irq), 32'(prev_cond));
    cnd = model_cond();
    chk("R11 rx ready", 32'(probe_rx_ready), 32'(!rxfull_pre));
    chk("R2 tx valid", 32'(probe_tx_valid), 32'(!txempty_pre));
    if (sel && !wr)
      chk({req, " read"}, bus_rdata, model_read(a));
    if (txp && !txempty_pre) begin
      chk("R2 tx head data", probe_tx_data, mtx[0][31:0]);
      chk("R2 tx head chan", 32'(probe_tx_chan), 32'(mtx[0][35:32]));
      void'(mtx.pop_front());
    end
    if (sel && wr && a >= 8'h20 && a <= 8'h98 && a[2:0] == 0) begin
      if (!txfull_pre) mtx.push_back({4'((a - 8'h20) >> 3), wd});
      else m_ovf = 1;
    end else if (sel && wr && a == 8'h00 && wd[0]) m_ovf = 0;
    else if (sel && wr && a == 8'h08) begin
      m_txsel = wd[19:18]; m_rxsel = wd[17:16];
    end
    if (sel && !wr && a == 8'h18 && !rxempty_pre) void'(mrx.pop_front());
    if (rxp && !rxfull_pre) mrx.push_back({rxc, rxd});
    prev_cond = cnd;
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0,0,"idle"); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    step(1,0,8'h10,0,0,0,0,0,"R1 status");
    step(1,0,8'h08,0,0,0,0,0,"R1 config");
    step(1,0,8'h00,0,0,0,0,0,"R1 acs");
    // R7 empty receive read
    step(1,0,8'h18,0,0,0,0,0,"R7 empty rx");
    step(1,0,8'h10,0,0,0,0,0,"R7 status after empty read");
    // R5 depth fields ignore writes
    step(1,1,8'h08,32'hFFFF_FFFF,0,0,0,0,"R5");
    step(1,0,8'h08,0,0,0,0,0,"R5 config");
    // R2 R6 fill past depth on varied channels
    for (int i = 0; i < TXD + 2; i++)
      step(1,1,8'(8'h20 + 8*(i % 16)),32'hA000_0000 + i,0,0,0,0,"R6 fill");
    step(1,0,8'h10,0,0,0,0,0,"R4 tx full status");
    step(1,0,8'h00,0,0,0,0,0,"R6 ovf set");
    step(1,1,8'h00,32'h0,0,0,0,0,"R6 write0");
    step(1,0,8'h00,0,0,0,0,0,"R6 ovf kept");
    step(1,1,8'h00,32'h1,0,0,0,0,"R6 clear");
    step(1,0,8'h00,0,0,0,0,0,"R6 ovf cleared");
    // R11 fill receive past depth, R3 head tag
    for (int i = 0; i < RXD + 2; i++)
      step(0,0,0,0,1,4'(15 - i),32'hB000_0000 + i,1,"R11 fill");
    step(1,0,8'h10,0,0,0,0,0,"R3 R4 rx full status");
    step(1,0,8'h18,0,0,0,0,0,"R3 pop");
    step(1,0,8'h10,0,0,0,0,0,"R3 next head");
    // R8 R9 R10 random traffic
    for (int i = 0; i < 4000; i++) begin
      int r, fill;
      logic [7:0] a;
      fill = ((i / 400) % 2 == 0);
      r = $urandom_range(0, 99);
      a = 8'(8'h20 + 8 * $urandom_range(0, 15));
      if (r < (fill ? 45 : 15))
        step(1,1,a,$urandom,$urandom_range(0,99) < (fill ? 20 : 60),
             4'($urandom),$urandom,$urandom_range(0,99) < (fill ? 15 : 60),"R2 rnd");
      else if (r < 60)
        step(1,0,8'h18,0,$urandom_range(0,99) < (fill ? 60 : 20),4'($urandom),
             $urandom,$urandom_range(0,99) < 30,"R3 rnd");
      else if (r < 75)
        step(1,0,8'h10,0,$urandom_range(0,99) < 40,4'($urandom),$urandom,
             $urandom_range(0,99) < 40,"R4 rnd");
      else if (r < 82)
        step(1,1,8'h08,$urandom,0,0,0,0,"R8 R9 cfg");
      else if (r < 86)
        step(1,0,8'h08,0,0,0,0,0,"R5 rnd");
      else if (r < 90)
        step(1,0,8'h00,0,0,0,0,0,"R6 rnd");
      else if (r < 93)
        step(1,1,8'h00,32'h1,0,0,0,0,"R6 clr");
      else
        step(0,0,0,0,$urandom_range(0,99) < 50,4'($urandom),$urandom,
             $urandom_range(0,99) < 50,"R10 idle");
    end
    idle(); idle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule